// File: doc/BRIEF.md
# ADC Conversion Sequencer with Interrupt Pacing

This control block sits beside an analog-to-digital converter. Software programs it through one 16-bit control word. From that word it decides how many sample/hold channels take part in each conversion operation. It also picks the positive input of channel 0, which is either a fixed selection or a walk through a mask of scan inputs. An optional mode alternates between two sample settings, A and B, on successive operations.

The converter reports each finished sample/conversion operation with a one-cycle `conv_done` strobe. The block counts these strobes. After a programmable number of them it raises either an interrupt pulse or a DMA-address-advance pulse. Which one is chosen by a mode input, and that input also changes the range of the programmable count. The block also produces the write address for conversion results. In split mode the result buffer is used as two halves, and a readable status bit reports which half is being filled.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The control word read on `cfg_rdata` holds a reference setting in bits 15:13, the scan enable in bit 10, the channel count in bits 9:8, the fill-half status in bit 7, the rate in bits 6:2, the split-buffer enable in bit 1 and the alternate-sample enable in bit 0. Bits 12:11 always read 0. Bit 7 ignores writes. After reset every field reads 0.
- R2: `ch_en` (bit i = channel i converted) is 4'b0001 for count 00, 4'b0011 for count 01 and 4'b1111 for count 10 or 11.
- R3: While `res12_mode` is 1, the channel count reads back as 00 and `ch_en` is 4'b0001, whatever value was written.
- R4: With `dma_mode` 0, `irq` fires after every N+1 accepted `conv_done` strobes, where N is rate bits 3:0. Rate bit 4 is ignored and `dma_inc` stays 0.
- R5: With `dma_mode` 1, `dma_inc` fires after every N+1 accepted strobes, where N is the full 5-bit rate (0 to 31), and `irq` stays 0.
- R6: `irq` and `dma_inc` are one-cycle pulses. They are high exactly in the cycle after the qualifying `conv_done`.
- R7: When scan enable is 1, the mask is non-zero and the current operation uses sample A, `ch0_pos` is the first set mask bit at or above the scan pointer, searching upward and wrapping. Each accepted sample-A strobe moves the pointer one past that input. Otherwise `ch0_pos` is `ch0_sel_a` for sample A and `ch0_sel_b` for sample B.
- R8: With alternate enable 1, `use_sample_b` toggles on every accepted strobe, starting at 0 (sample A). With alternate enable 0 it stays 0.
- R9: Each accepted strobe that does not end a pacing period moves `buf_waddr` forward by the number of converted channels. A strobe that ends a period returns the offset to 0. Without split mode `buf_waddr` is the offset, across the whole buffer.
- R10: In split mode, every period end toggles the fill half, which reads back in bit 7. `buf_waddr` is then {half, offset in the half}, with the half as the top address bit. Without split mode bit 7 reads 0.
- R11: A control write clears the conversion counter, scan pointer, sample phase, buffer offset and fill half. A `conv_done` in the same cycle as the write is ignored.
- R12: A change of `dma_mode` clears the conversion counter and the scan pointer. A `conv_done` in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read value including status |
| res12_mode | input | 1 | High-resolution mode; forces a single channel |
| dma_mode | input | 1 | Selects DMA-advance pacing instead of interrupt pacing |
| scan_mask | input | SCAN_N | Scan inputs enabled for channel 0 |
| ch0_sel_a | input | log2(SCAN_N) | Fixed channel 0 input for sample A |
| ch0_sel_b | input | log2(SCAN_N) | Fixed channel 0 input for sample B |
| conv_done | input | 1 | One sample/conversion operation finished |
| ch_en | output | 4 | Channels converted in the current operation |
| ch0_pos | output | log2(SCAN_N) | Channel 0 positive input selection |
| use_sample_b | output | 1 | Current operation uses the sample B settings |
| buf_waddr | output | log2(BUF_DEPTH) | Result buffer write address |
| irq | output | 1 | Interrupt pulse |
| dma_inc | output | 1 | DMA address advance pulse |

## Verification
The assertions assume that `cfg_wr`, `conv_done` and `dma_mode` are held low during reset and are sampled only at clock edges. They also assume a control word changes only through `cfg_wr`, which is why sample B can be seen only with the alternate bit set. The stimulus meets these assumptions: every input changes on the falling edge, and reset is released with all strobes low. Randomly chosen writes, strobes, mode flips and mask changes are mixed in. Rate values are biased toward small numbers so that many pacing periods complete.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    localparam int unsigned NUM_SH   = 4;
    localparam int unsigned RATE_W   = 5;
    localparam int unsigned NCH_W    = 3;
    localparam logic [15:0] WR_MASK  = 16'hE77F;

    typedef struct packed {
        logic [2:0]        vref;
        logic              scan_en;
        logic [1:0]        nch_sel;
        logic [RATE_W-1:0] rate;
        logic              split;
        logic              alt_en;
    } seq_cfg_t;

    function automatic seq_cfg_t cfg_from_word(logic [15:0] w);
        seq_cfg_t c;
        c.vref    = w[15:13];
        c.scan_en = w[10];
        c.nch_sel = w[9:8];
        c.rate    = w[6:2];
        c.split   = w[1];
        c.alt_en  = w[0];
        return c;
    endfunction

    function automatic logic [15:0] word_from_cfg(seq_cfg_t c, logic res12, logic half);
        logic [15:0] w;
        w        = '0;
        w[15:13] = c.vref;
        w[10]    = c.scan_en;
        w[9:8]   = res12 ? 2'b00 : c.nch_sel;
        w[7]     = half & c.split;
        w[6:2]   = c.rate;
        w[1]     = c.split;
        w[0]     = c.alt_en;
        return w;
    endfunction

    function automatic logic [NCH_W-1:0] chan_count(logic [1:0] sel, logic res12);
        if (res12 || sel == 2'b00) return NCH_W'(1);
        if (sel == 2'b01)          return NCH_W'(2);
        return NCH_W'(4);
    endfunction

endpackage

// File: rtl/adc_seq_regs.sv
`timescale 1ns/1ps
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wdata,
    input  logic        res12,
    input  logic        fill_half,
    output seq_cfg_t    cfg,
    output logic [15:0] rdata
);
    seq_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) cfg_d = cfg_from_word(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg   = cfg_q;
    assign rdata = word_from_cfg(cfg_q, res12, fill_half);
endmodule

// File: rtl/adc_seq_pacer.sv
`timescale 1ns/1ps
module adc_seq_pacer
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              dma_mode,
    input  logic [RATE_W-1:0] rate,
    output logic              period_end,
    output logic              irq,
    output logic              dma_inc
);
    typedef struct packed {
        logic [RATE_W-1:0] cnt;
        logic              irq;
        logic              dma;
    } pace_t;

    pace_t             s_d, s_q;
    logic [RATE_W-1:0] limit;

    always_comb begin
        limit      = dma_mode ? rate : {1'b0, rate[RATE_W-2:0]};
        period_end = step && (s_q.cnt == limit);
        s_d        = s_q;
        s_d.irq    = 1'b0;
        s_d.dma    = 1'b0;
        if (clear) begin
            s_d.cnt = '0;
        end else if (step) begin
            if (period_end) begin
                s_d.cnt = '0;
                s_d.irq = !dma_mode;
                s_d.dma = dma_mode;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq     = s_q.irq;
    assign dma_inc = s_q.dma;
endmodule

// File: rtl/adc_seq_scan.sv
`timescale 1ns/1ps
module adc_seq_scan #(
    parameter  int unsigned SCAN_N = 16,
    localparam int unsigned SEL_W  = $clog2(SCAN_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_phase,
    input  logic              clear_ptr,
    input  logic              step,
    input  logic              scan_en,
    input  logic              alt_en,
    input  logic [SCAN_N-1:0] mask,
    input  logic [SEL_W-1:0]  sel_a,
    input  logic [SEL_W-1:0]  sel_b,
    output logic [SEL_W-1:0]  ch0_pos,
    output logic              phase_b
);
    typedef struct packed {
        logic [SEL_W-1:0] ptr;
        logic             ph_b;
    } scan_t;

    scan_t            s_d, s_q;
    logic             hit;
    logic [SEL_W-1:0] hit_pos;
    logic             scanning;

    always_comb begin
        hit     = 1'b0;
        hit_pos = '0;
        for (int k = 0; k < int'(SCAN_N); k++) begin
            int idx;
            idx = int'(s_q.ptr) + k;
            if (idx >= int'(SCAN_N)) idx = idx - int'(SCAN_N);
            if (!hit && mask[idx]) begin
                hit     = 1'b1;
                hit_pos = SEL_W'(idx);
            end
        end
    end

    always_comb begin
        scanning = scan_en && hit && !s_q.ph_b;
        s_d      = s_q;
        if (clear_phase) s_d.ph_b = 1'b0;
        if (clear_ptr) begin
            s_d.ptr = '0;
        end else if (step) begin
            if (scanning)
                s_d.ptr = (hit_pos == SEL_W'(SCAN_N - 1)) ? '0 : hit_pos + 1'b1;
            if (alt_en)
                s_d.ph_b = !s_q.ph_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ch0_pos = s_q.ph_b ? sel_b : (scanning ? hit_pos : sel_a);
    assign phase_b = s_q.ph_b;
endmodule

// File: rtl/adc_seq_bufaddr.sv
`timescale 1ns/1ps
module adc_seq_bufaddr
    import adc_seq_pkg::*;
#(
    parameter  int unsigned BUF_DEPTH = 256,
    localparam int unsigned AW        = $clog2(BUF_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             period_end,
    input  logic [NCH_W-1:0] nch,
    input  logic             split,
    output logic [AW-1:0]    waddr,
    output logic             half
);
    typedef struct packed {
        logic [AW-1:0] off;
        logic          half;
    } buf_t;

    buf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else if (step) begin
            if (period_end) begin
                s_d.off  = '0;
                s_d.half = s_q.half ^ split;
            end else begin
                s_d.off  = s_q.off + AW'(nch);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign waddr = split ? {s_q.half, s_q.off[AW-2:0]} : s_q.off;
    assign half  = s_q.half;
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter  int unsigned SCAN_N    = 16,
    parameter  int unsigned BUF_DEPTH = 256,
    localparam int unsigned SEL_W     = $clog2(SCAN_N),
    localparam int unsigned AW        = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              res12_mode,
    input  logic              dma_mode,
    input  logic [SCAN_N-1:0] scan_mask,
    input  logic [SEL_W-1:0]  ch0_sel_a,
    input  logic [SEL_W-1:0]  ch0_sel_b,
    input  logic              conv_done,
    output logic [NUM_SH-1:0] ch_en,
    output logic [SEL_W-1:0]  ch0_pos,
    output logic              use_sample_b,
    output logic [AW-1:0]     buf_waddr,
    output logic              irq,
    output logic              dma_inc
);
    seq_cfg_t         cfg;
    logic             mode_d, mode_q;
    logic             mode_flip;
    logic             step;
    logic             period_end;
    logic             fill_half;
    logic [NCH_W-1:0] nch;

    always_comb begin
        mode_d    = dma_mode;
        mode_flip = (dma_mode != mode_q);
        step      = conv_done && !cfg_wr && !mode_flip;
        nch       = chan_count(cfg.nch_sel, res12_mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_d;
    end

    generate
        for (genvar g = 0; g < int'(NUM_SH); g++) begin : g_chen
            assign ch_en[g] = (NCH_W'(g) < nch);
        end
    endgenerate

    adc_seq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .wdata     (cfg_wdata),
        .res12     (res12_mode),
        .fill_half (fill_half),
        .cfg       (cfg),
        .rdata     (cfg_rdata)
    );

    adc_seq_pacer u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cfg_wr || mode_flip),
        .step       (step),
        .dma_mode   (dma_mode),
        .rate       (cfg.rate),
        .period_end (period_end),
        .irq        (irq),
        .dma_inc    (dma_inc)
    );

    adc_seq_scan #(.SCAN_N(SCAN_N)) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_phase (cfg_wr),
        .clear_ptr   (cfg_wr || mode_flip),
        .step        (step),
        .scan_en     (cfg.scan_en),
        .alt_en      (cfg.alt_en),
        .mask        (scan_mask),
        .sel_a       (ch0_sel_a),
        .sel_b       (ch0_sel_b),
        .ch0_pos     (ch0_pos),
        .phase_b     (use_sample_b)
    );

    adc_seq_bufaddr #(.BUF_DEPTH(BUF_DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cfg_wr),
        .step       (step),
        .period_end (period_end),
        .nch        (nch),
        .split      (cfg.split),
        .waddr      (buf_waddr),
        .half       (fill_half)
    );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
`timescale 1ns/1ps
module adc_seq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [15:0] cfg_rdata,
    input logic        res12_mode,
    input logic        dma_mode,
    input logic        conv_done,
    input logic [3:0]  ch_en,
    input logic        use_sample_b,
    input logic        irq,
    input logic        dma_inc
);
    p_unimpl_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[12:11] == 2'b00);

    p_chen_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en == 4'b0001) || (ch_en == 4'b0011) || (ch_en == 4'b1111));

    p_res12_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res12_mode |-> (ch_en == 4'b0001) && (cfg_rdata[9:8] == 2'b00));

    p_irq_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(dma_mode));

    p_dma_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_inc |-> $past(dma_mode));

    p_pulse_follows_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || dma_inc) |-> $past(conv_done));

    p_no_alt_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[0] |-> !use_sample_b);

    p_status_split_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[1] |-> !cfg_rdata[7]);

    p_write_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !irq && !dma_inc && !use_sample_b);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (.*);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
    localparam int SCAN_N = 16;
    localparam int BUF_DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        res12_mode = 1'b0;
    logic        dma_mode = 1'b0;
    logic [15:0] scan_mask = '0;
    logic [3:0]  ch0_sel_a = '0;
    logic [3:0]  ch0_sel_b = '0;
    logic        conv_done = 1'b0;
    logic [3:0]  ch_en;
    logic [3:0]  ch0_pos;
    logic        use_sample_b;
    logic [7:0]  buf_waddr;
    logic        irq;
    logic        dma_inc;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference state
    logic [15:0] m_cfg = '0;
    logic [4:0]  m_cnt = '0;
    logic [3:0]  m_ptr = '0;
    logic        m_phb = 1'b0;
    logic [7:0]  m_off = '0;
    logic        m_half = 1'b0;
    logic        m_dmaq = 1'b0;
    logic        m_irq = 1'b0;
    logic        m_dmi = 1'b0;

    always #2.5 clk = ~clk;

    adc_seq_ctrl #(.SCAN_N(SCAN_N), .BUF_DEPTH(BUF_DEPTH)) u_adc_seq_ctrl (.*);

    function automatic int first_set(logic [15:0] m, logic [3:0] p);
        for (int k = 0; k < 16; k++) begin
            int i;
            i = (int'(p) + k) % 16;
            if (m[i]) return i;
        end
        return -1;
    endfunction

    function automatic int nch_of();
        if (res12_mode || m_cfg[9:8] == 2'b00) return 1;
        if (m_cfg[9:8] == 2'b01) return 2;
        return 4;
    endfunction

    function automatic logic [15:0] exp_rdata();
        logic [15:0] w;
        w = m_cfg;
        if (res12_mode) w[9:8] = 2'b00;
        w[7] = m_cfg[1] & m_half;
        return w;
    endfunction

    function automatic logic [15:0] exp_chen();
        int n;
        n = nch_of();
        return (n == 1) ? 16'h1 : (n == 2) ? 16'h3 : 16'hF;
    endfunction

    function automatic logic [15:0] exp_pos();
        int f;
        f = first_set(scan_mask, m_ptr);
        if (m_phb) return 16'(ch0_sel_b);
        if (m_cfg[10] && f >= 0) return 16'(f);
        return 16'(ch0_sel_a);
    endfunction

    function automatic logic [15:0] exp_waddr();
        if (m_cfg[1]) return 16'({m_half, m_off[6:0]});
        return 16'(m_off);
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        logic flip;
        flip = (dma_mode != m_dmaq);
        m_irq = 1'b0;
        m_dmi = 1'b0;
        if (cfg_wr) begin
            m_cfg = cfg_wdata & 16'hE77F;
            m_cnt = '0; m_ptr = '0; m_phb = 1'b0; m_off = '0; m_half = 1'b0;
        end else if (flip) begin
            m_cnt = '0; m_ptr = '0;
        end else if (conv_done) begin
            logic [4:0] lim;
            int f;
            lim = dma_mode ? m_cfg[6:2] : {1'b0, m_cfg[5:2]};
            if (m_cnt == lim) begin
                if (dma_mode) m_dmi = 1'b1; else m_irq = 1'b1;
                m_cnt = '0;
                m_off = '0;
                if (m_cfg[1]) m_half = !m_half;
            end else begin
                m_cnt = m_cnt + 1'b1;
                m_off = m_off + 8'(nch_of());
            end
            f = first_set(scan_mask, m_ptr);
            if (m_cfg[10] && !m_phb && f >= 0) m_ptr = 4'((f + 1) % 16);
            if (m_cfg[0]) m_phb = !m_phb;
        end
        m_dmaq = dma_mode;
    endtask

    task automatic compare_all();
        chk("R1 cfg_rdata", cfg_rdata, exp_rdata());
        chk("R2 ch_en", 16'(ch_en), exp_chen());
        chk("R4 irq", 16'(irq), 16'(m_irq));
        chk("R5 dma_inc", 16'(dma_inc), 16'(m_dmi));
        chk("R7 ch0_pos", 16'(ch0_pos), exp_pos());
        chk("R8 use_sample_b", 16'(use_sample_b), 16'(m_phb));
        chk("R9 buf_waddr", 16'(buf_waddr), exp_waddr());
        chk("R10 fill status", 16'(cfg_rdata[7]), 16'(m_cfg[1] & m_half));
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(logic [15:0] w);
        cfg_wr = 1'b1; cfg_wdata = w;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic pulse();
        conv_done = 1'b1; tick(); conv_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset rdata", cfg_rdata, 16'h0);
        chk("R1 reset irq/dma", 16'({irq, dma_inc, use_sample_b}), 16'h0);
        chk("R9 reset waddr", 16'(buf_waddr), 16'h0);

        // R1: unimplemented and status bits ignore writes
        wr(16'hFFFF);
        chk("R1 read-back all ones", cfg_rdata, 16'hE77F);
        // R3: high-resolution mode hides the channel count
        res12_mode = 1'b1; tick();
        chk("R3 count reads 0", 16'(cfg_rdata[9:8]), 16'h0);
        chk("R3 single channel", 16'(ch_en), 16'h1);
        res12_mode = 1'b0;

        // R4/R6: rate 3, interrupt after the fourth strobe only
        wr(16'h000C);
        repeat (3) begin pulse(); chk("R4 no early irq", 16'(irq), 16'h0); end
        pulse();
        chk("R6 irq the cycle after done", 16'(irq), 16'h1);
        tick();
        chk("R6 irq single cycle", 16'(irq), 16'h0);

        // R4: rate bit 4 ignored in interrupt pacing
        wr(16'h004C);
        repeat (3) pulse();
        pulse();
        chk("R4 bit4 ignored", 16'(irq), 16'h1);

        // R5: DMA pacing with rate 31
        dma_mode = 1'b1; tick();
        wr(16'h007C);
        repeat (31) pulse();
        chk("R5 no advance before 32", 16'(dma_inc), 16'h0);
        pulse();
        chk("R5 advance on 32nd", 16'(dma_inc), 16'h1);
        dma_mode = 1'b0; tick();

        // R10: split buffer half toggles with each interrupt
        wr(16'h0302);
        pulse();
        chk("R10 half set", 16'(cfg_rdata[7]), 16'h1);
        chk("R10 upper half address", 16'(buf_waddr), 16'h80);
        pulse();
        chk("R10 half cleared", 16'(cfg_rdata[7]), 16'h0);

        // R11: strobe together with a write is ignored
        conv_done = 1'b1; wr(16'h0000); conv_done = 1'b0;
        chk("R11 no irq on write cycle", 16'(irq), 16'h0);

        // R12: dma_mode change clears the counter
        wr(16'h0004);
        pulse();
        dma_mode = 1'b1; tick();
        pulse();
        chk("R12 counter restarted", 16'(dma_inc), 16'h0);
        pulse();
        chk("R12 advance after two", 16'(dma_inc), 16'h1);
        dma_mode = 1'b0; tick();

        // R7/R8: scan with alternate sampling, directed
        scan_mask = 16'h0824; ch0_sel_a = 4'd1; ch0_sel_b = 4'd9;
        wr(16'h0401);
        chk("R7 first scan input", 16'(ch0_pos), 16'd2);
        pulse();
        chk("R8 sample B selection", 16'(ch0_pos), 16'd9);
        pulse();
        chk("R7 next scan input", 16'(ch0_pos), 16'd5);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            cfg_wr = ($urandom % 40) == 0;
            if (cfg_wr) begin
                logic [15:0] w;
                w = 16'($urandom);
                w[6:2] = (($urandom % 4) == 0) ? 5'($urandom) : 5'($urandom % 4);
                cfg_wdata = w;
            end
            conv_done = ($urandom % 3) == 0;
            if (($urandom % 300) == 0) dma_mode = !dma_mode;
            if (($urandom % 400) == 0) res12_mode = !res12_mode;
            if (($urandom % 100) == 0) scan_mask = (($urandom % 5) == 0) ? 16'h0 : 16'($urandom);
            if (($urandom % 100) == 0) begin
                ch0_sel_a = 4'($urandom); ch0_sel_b = 4'($urandom);
            end
            tick();
        end
        cfg_wr = 1'b0; conv_done = 1'b0;
        tick();
        finish_run();
    end
endmodule